// File: doc/BRIEF.md
# Dual-Level Threshold Trigger

This block watches a stream of signed sample words, each marked by a valid strobe. It compares every valid sample against two programmable levels, a lower one and an upper one. Each comparison result is a sensitive input to a small set/clear machine. A 2-bit action code for each edge direction of each comparator says what a rising or falling comparator output does to the trigger state. When the state goes from clear to set, the block emits a pulse one clock wide.

Two optional qualification windows, counted in valid samples, can delay the set and the clear. The trigger is then only asserted, or only released, if the condition that asked for it is not cancelled inside the window. The configuration is checked continuously. If the lower level is not below the upper level, the block reports an error and stays disarmed. The one exception is single-comparator use, where the upper comparator is switched off.

Top module: `dlt_trigger`

## Requirements
- R1: Each comparator output is 1 only when the sample, read as two's complement, is strictly greater than its level. A sample equal to the level gives 0.
- R2: Comparator edges are taken only between consecutive valid samples. The first valid sample after reset, or after a configuration error, only sets the baseline. Cycles with `smp_valid` low change neither the state nor the pulse.
- R3: Each action code decodes as 2'b00 ignore, 2'b01 set request, 2'b10 clear request, and 2'b11 reserved, which acts as ignore. Index 0 of each code pair belongs to the lower comparator and index 1 to the upper one, with separate codes for rising and falling edges.
- R4: Both comparators are sensitive inputs. If both produce a non-ignore request on the same sample, the upper comparator's request wins.
- R5: `trig_pulse` is high for exactly one clock, in the cycle after the edge that moves the state from clear to set. `trig_state` is high from that cycle for as long as the state is set. Leaving the set state never pulses.
- R6: With `set_hold` = N > 0, a set request from the clear state asserts the trigger on the Nth following valid sample, unless a clear request arrives first, which cancels it. N = 0 asserts the trigger at once.
- R7: With `clr_hold` = M > 0, a clear request from the set state releases the trigger on the Mth following valid sample, unless a set request arrives first. In that case the state stays set and no new pulse is produced. M = 0 releases the trigger at once.
- R8: If `lvl_lo` >= `lvl_hi` (signed) outside single-comparator mode, `cfg_err` is 1. The state is then forced clear, no pulse is produced, and the comparator history is dropped.
- R9: Single-comparator mode is when both upper action codes are 2'b00 and `lvl_hi` is 0. In this mode `cfg_err` stays 0 whatever the value of `lvl_lo`.
- R10: After reset, `trig_pulse` and `trig_state` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW | Signed sample word |
| lvl_lo | input | DW | Signed lower (primary) level |
| lvl_hi | input | DW | Signed upper (secondary) level |
| act_rise | input | 2x2 | Action code per comparator for a rising output, [0] lower, [1] upper |
| act_fall | input | 2x2 | Action code per comparator for a falling output |
| set_hold | input | QW | Valid samples needed to qualify a set |
| clr_hold | input | QW | Valid samples needed to qualify a clear |
| trig_pulse | output | 1 | One-clock trigger pulse |
| trig_state | output | 1 | Current trigger state |
| cfg_err | output | 1 | Level ordering violated outside single-comparator mode |

## Verification
The bench sweeps all 256 action-code combinations over a waveform that crosses the levels one at a time, and also jumps across both levels in a single sample. A design with the wrong override order, or with code 11 acting as set or clear, would then pulse on the wrong sample. Samples equal to a level, and the first sample after reset, must not produce an edge. A non-strict compare or an unprimed history would fire early. Every pair of hold values from 0 to 3 is run against high and low runs of lengths 1 to 4. An off-by-one in the qualification count, or a release that pulses on re-entry, shows up as a shifted or extra pulse. A grid of level pairs, single-comparator settings and an ordering fault raised mid-run checks that an error disarms the trigger and that single mode is never flagged.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_RSVD = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMING,
    ST_ACTIVE,
    ST_DISARM
  } st_e;

  typedef struct packed {
    logic set;
    logic clr;
  } req_t;

  // reserved code behaves like ignore
  function automatic req_t decode_act(input logic [1:0] code);
    req_t r;
    r.set = (code == ACT_SET);
    r.clr = (code == ACT_CLR);
    return r;
  endfunction

endpackage

// File: rtl/dlt_rst_sync.sv
module dlt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = sync_q[1];

endmodule

// File: rtl/dlt_compare.sv
module dlt_compare #(
  parameter int DW  = 12,
  parameter int NCH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid,
  input  logic                     flush,
  input  logic [DW-1:0]            sample,
  input  logic [NCH-1:0][DW-1:0]   levels,
  output logic [NCH-1:0]           rise,
  output logic [NCH-1:0]           fall
);

  logic [NCH-1:0] cmp_now;
  logic [NCH-1:0] cmp_q;
  logic [NCH-1:0] cmp_nxt;
  logic           primed_q;
  logic           primed_nxt;
  logic           cmp_en;
  logic           edge_ok;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
    assign cmp_now[ch] = $signed(sample) > $signed(levels[ch]);
    assign rise[ch]    = edge_ok &  cmp_now[ch] & ~cmp_q[ch];
    assign fall[ch]    = edge_ok & ~cmp_now[ch] &  cmp_q[ch];
  end

  assign edge_ok = valid & primed_q & ~flush;
  assign cmp_en  = valid & ~flush;

  always_comb begin
    cmp_nxt    = cmp_q;
    primed_nxt = primed_q;
    if (flush) begin
      primed_nxt = 1'b0;
    end else if (cmp_en) begin
      cmp_nxt    = cmp_now;
      primed_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      cmp_q    <= cmp_nxt;
      primed_q <= primed_nxt;
    end
  end

endmodule

// File: rtl/dlt_action_merge.sv
module dlt_action_merge
  import dlt_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0]       rise,
  input  logic [NCH-1:0]       fall,
  input  logic [NCH-1:0][1:0]  act_rise,
  input  logic [NCH-1:0][1:0]  act_fall,
  output req_t                 req
);

  // higher channel index overrides lower when it asks for something
  always_comb begin
    req_t r;
    req = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      r = '0;
      if (rise[ch]) begin
        r = decode_act(act_rise[ch]);
      end else if (fall[ch]) begin
        r = decode_act(act_fall[ch]);
      end
      if (r.set || r.clr) begin
        req = r;
      end
    end
  end

endmodule

// File: rtl/dlt_qualify_fsm.sv
module dlt_qualify_fsm
  import dlt_pkg::*;
#(
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          flush,
  input  req_t          req,
  input  logic [QW-1:0] set_hold,
  input  logic [QW-1:0] clr_hold,
  output logic          trig_state,
  output logic          trig_pulse
);

  st_e           st_q, st_nxt;
  logic [QW-1:0] cnt_q, cnt_nxt;
  logic          pulse_q, pulse_nxt;
  logic [QW:0]   cnt_inc;
  logic [QW:0]   set_lim;
  logic [QW:0]   clr_lim;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign set_lim = {1'b0, set_hold};
  assign clr_lim = {1'b0, clr_hold};

  always_comb begin
    st_nxt    = st_q;
    cnt_nxt   = cnt_q;
    pulse_nxt = 1'b0;
    if (flush) begin
      st_nxt  = ST_IDLE;
      cnt_nxt = '0;
    end else if (valid) begin
      unique case (st_q)
        ST_IDLE: begin
          if (req.set) begin
            cnt_nxt = '0;
            if (set_hold == '0) begin
              st_nxt    = ST_ACTIVE;
              pulse_nxt = 1'b1;
            end else begin
              st_nxt = ST_ARMING;
            end
          end
        end
        ST_ARMING: begin
          if (req.clr) begin
            st_nxt  = ST_IDLE;
            cnt_nxt = '0;
          end else if (cnt_inc == set_lim) begin
            st_nxt    = ST_ACTIVE;
            cnt_nxt   = '0;
            pulse_nxt = 1'b1;
          end else begin
            cnt_nxt = cnt_inc[QW-1:0];
          end
        end
        ST_ACTIVE: begin
          if (req.clr) begin
            cnt_nxt = '0;
            st_nxt  = (clr_hold == '0) ? ST_IDLE : ST_DISARM;
          end
        end
        ST_DISARM: begin
          if (req.set) begin
            st_nxt  = ST_ACTIVE;
            cnt_nxt = '0;
          end else if (cnt_inc == clr_lim) begin
            st_nxt  = ST_IDLE;
            cnt_nxt = '0;
          end else begin
            cnt_nxt = cnt_inc[QW-1:0];
          end
        end
        default: begin
          st_nxt  = ST_IDLE;
          cnt_nxt = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_nxt;
      cnt_q   <= cnt_nxt;
      pulse_q <= pulse_nxt;
    end
  end

  assign trig_state = (st_q == ST_ACTIVE) || (st_q == ST_DISARM);
  assign trig_pulse = pulse_q;

endmodule

// File: rtl/dlt_trigger.sv
module dlt_trigger
  import dlt_pkg::*;
#(
  parameter int DW = 12,
  parameter int QW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic [DW-1:0]        smp_data,
  input  logic [DW-1:0]        lvl_lo,
  input  logic [DW-1:0]        lvl_hi,
  input  logic [1:0][1:0]      act_rise,
  input  logic [1:0][1:0]      act_fall,
  input  logic [QW-1:0]        set_hold,
  input  logic [QW-1:0]        clr_hold,
  output logic                 trig_pulse,
  output logic                 trig_state,
  output logic                 cfg_err
);

  localparam int NCH = 2;

  logic                  rst_core_n;
  logic                  single_mode;
  logic [NCH-1:0][DW-1:0] lvls;
  logic [NCH-1:0]        rise;
  logic [NCH-1:0]        fall;
  req_t                  req;

  dlt_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  assign single_mode = (act_rise[1] == ACT_NONE) && (act_fall[1] == ACT_NONE)
                       && (lvl_hi == '0);
  assign cfg_err     = !single_mode && ($signed(lvl_lo) >= $signed(lvl_hi));
  assign lvls        = {lvl_hi, lvl_lo};

  dlt_compare #(.DW(DW), .NCH(NCH)) i_compare (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .valid  (smp_valid),
    .flush  (cfg_err),
    .sample (smp_data),
    .levels (lvls),
    .rise   (rise),
    .fall   (fall)
  );

  dlt_action_merge #(.NCH(NCH)) i_merge (
    .rise     (rise),
    .fall     (fall),
    .act_rise (act_rise),
    .act_fall (act_fall),
    .req      (req)
  );

  dlt_qualify_fsm #(.QW(QW)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .valid      (smp_valid),
    .flush      (cfg_err),
    .req        (req),
    .set_hold   (set_hold),
    .clr_hold   (clr_hold),
    .trig_state (trig_state),
    .trig_pulse (trig_pulse)
  );

endmodule

// File: rtl/dlt_trigger_chk.sv
module dlt_trigger_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_valid,
  input logic cfg_err,
  input logic trig_state,
  input logic trig_pulse
);

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  // R5
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $rose(trig_state));

  // R5
  rise_has_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_state) |-> trig_pulse);

  // R2
  idle_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !cfg_err) |=> ($stable(trig_state) && !trig_pulse));

  // R8
  err_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (!trig_state && !trig_pulse));

endmodule

bind dlt_trigger dlt_trigger_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .smp_valid  (smp_valid),
  .cfg_err    (cfg_err),
  .trig_state (trig_state),
  .trig_pulse (trig_pulse)
);

// File: tb/test_dlt_trigger.sv
module test_dlt_trigger;

  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int QW    = 4;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                smp_valid;
  logic signed [DW-1:0] smp_data;
  logic signed [DW-1:0] lvl_lo;
  logic signed [DW-1:0] lvl_hi;
  logic [1:0][1:0]     act_rise;
  logic [1:0][1:0]     act_fall;
  logic [QW-1:0]       set_hold;
  logic [QW-1:0]       clr_hold;
  logic                trig_pulse;
  logic                trig_state;
  logic                cfg_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  bit m_c0, m_c1, m_primed, e_pulse;
  int m_st, m_cnt; // 0 idle, 1 arming, 2 active, 3 disarm

  always #(CLK_P/2) clk = ~clk;

  dlt_trigger #(.DW(DW), .QW(QW)) i_dlt_trigger (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .lvl_lo(lvl_lo), .lvl_hi(lvl_hi), .act_rise(act_rise), .act_fall(act_fall),
    .set_hold(set_hold), .clr_hold(clr_hold),
    .trig_pulse(trig_pulse), .trig_state(trig_state), .cfg_err(cfg_err)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_err();
    bit single;
    single = (act_rise[1] == 2'b00) && (act_fall[1] == 2'b00) && (lvl_hi == 0);
    return !single && (int'(lvl_lo) >= int'(lvl_hi));
  endfunction

  // 1 set, 2 clear, 0 none
  function automatic int code_req(input logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 0;
  endfunction

  task automatic do_reset();
    smp_valid = 1'b0;
    smp_data  = '0;
    rst_n     = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_c0 = 0; m_c1 = 0; m_primed = 0; m_st = 0; m_cnt = 0; e_pulse = 0;
  endtask

  task automatic step(input bit v, input int s, input string tag);
    bit c0, c1, err;
    int r0, r1, rq;
    smp_valid = v;
    smp_data  = s[DW-1:0];
    err = exp_err();
    e_pulse = 0;
    if (err) begin
      m_primed = 0; m_st = 0; m_cnt = 0;
    end else if (v) begin
      c0 = (s > int'(lvl_lo));
      c1 = (s > int'(lvl_hi));
      r0 = 0; r1 = 0;
      if (m_primed) begin
        if (c0 && !m_c0) r0 = code_req(act_rise[0]);
        if (!c0 && m_c0) r0 = code_req(act_fall[0]);
        if (c1 && !m_c1) r1 = code_req(act_rise[1]);
        if (!c1 && m_c1) r1 = code_req(act_fall[1]);
      end
      rq = (r1 != 0) ? r1 : r0;
      m_c0 = c0; m_c1 = c1; m_primed = 1;
      case (m_st)
        0: if (rq == 1) begin
             m_cnt = 0;
             if (set_hold == 0) begin m_st = 2; e_pulse = 1; end else m_st = 1;
           end
        1: if (rq == 2) begin m_st = 0; m_cnt = 0; end
           else if (m_cnt + 1 == int'(set_hold)) begin m_st = 2; m_cnt = 0; e_pulse = 1; end
           else m_cnt++;
        2: if (rq == 2) begin m_cnt = 0; m_st = (clr_hold == 0) ? 0 : 3; end
        default: if (rq == 1) begin m_st = 2; m_cnt = 0; end
           else if (m_cnt + 1 == int'(clr_hold)) begin m_st = 0; m_cnt = 0; end
           else m_cnt++;
      endcase
    end
    @(negedge clk);
    check(tag, "trig_pulse", trig_pulse, e_pulse);
    check(tag, "trig_state", trig_state, (m_st >= 2));
    check(tag, "cfg_err", cfg_err, err);
  endtask

  task automatic set_cfg(input int lo, input int hi, input logic [1:0] r0, input logic [1:0] f0,
                         input logic [1:0] r1, input logic [1:0] f1, input int sh, input int ch);
    lvl_lo = lo[DW-1:0]; lvl_hi = hi[DW-1:0];
    act_rise[0] = r0; act_fall[0] = f0; act_rise[1] = r1; act_fall[1] = f1;
    set_hold = sh[QW-1:0]; clr_hold = ch[QW-1:0];
  endtask

  initial begin
    int wv[12];
    wv = '{-40, 0, 40, 0, -40, 40, -40, -40, 40, 100, 0, -40};
    set_cfg(10, 50, 2'b01, 2'b10, 2'b00, 2'b00, 0, 0);
    do_reset();
    // R10 reset state
    check("R10", "trig_pulse", trig_pulse, 1'b0);
    check("R10", "trig_state", trig_state, 1'b0);

    // R2 first sample is baseline only; R1 equal level gives no edge
    step(1, 60, "R2");
    check("R2", "first sample no pulse", trig_pulse, 1'b0);
    step(1, 5, "R2");
    step(1, 10, "R1");
    check("R1", "equal level no edge", trig_state, 1'b0);
    step(1, 11, "R1");
    check("R1", "above level sets", trig_pulse, 1'b1);
    step(0, -100, "R2");
    check("R2", "invalid cycle ignored", trig_state, 1'b1);
    step(1, 12, "R5");
    check("R5", "pulse one clock", trig_pulse, 1'b0);
    step(1, -9, "R5");
    check("R5", "clear no pulse", trig_pulse, 1'b0);

    // R3 R4: all action code combinations
    for (int code = 0; code < 256; code++) begin
      set_cfg(-20, 30, code[1:0], code[3:2], code[5:4], code[7:6], 0, 0);
      do_reset();
      for (int i = 0; i < 12; i++) begin
        step(1, wv[i], (i == 5 || i == 8) ? "R4" : "R3");
        if (i == 3 || i == 7) step(0, 127, "R2");
      end
    end

    // R6 R7: qualification windows
    for (int sh = 0; sh < 4; sh++) begin
      for (int ch = 0; ch < 4; ch++) begin
        set_cfg(0, 0, 2'b01, 2'b10, 2'b00, 2'b00, sh, ch);
        do_reset();
        step(1, -10, "R6");
        for (int len = 1; len <= 4; len++) begin
          for (int k = 0; k < len; k++) step(1, 10, "R6");
          for (int k = 0; k < len; k++) step(1, -10, "R7");
        end
        for (int k = 0; k < 5; k++) step(1, -10, "R7");
      end
    end

    // R8: level ordering grid
    for (int lo = -2; lo <= 2; lo += 2) begin
      for (int hi = -2; hi <= 2; hi += 2) begin
        set_cfg(lo, hi, 2'b01, 2'b10, 2'b01, 2'b10, 0, 0);
        do_reset();
        step(1, -5, "R8"); step(1, 5, "R8"); step(1, -5, "R8");
        step(1, 5, "R8"); step(1, 1, "R8"); step(1, -1, "R8");
      end
    end

    // R8: ordering fault raised while set
    set_cfg(-2, 2, 2'b01, 2'b10, 2'b00, 2'b00, 0, 0);
    do_reset();
    step(1, -5, "R8"); step(1, 5, "R8");
    lvl_hi = -3;
    step(0, 0, "R8");
    check("R8", "fault clears state", trig_state, 1'b0);
    lvl_hi = 2;
    step(1, 5, "R8");
    check("R8", "history dropped", trig_pulse, 1'b0);

    // R9: single-comparator mode never flags
    set_cfg(3, 0, 2'b01, 2'b10, 2'b00, 2'b00, 0, 0);
    do_reset();
    check("R9", "cfg_err", cfg_err, 1'b0);
    step(1, -5, "R9"); step(1, 5, "R9");
    check("R9", "single mode triggers", trig_pulse, 1'b1);
    step(1, -5, "R9");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule